// File: doc/BRIEF.md
# Flash LED Timing Controller

This block sequences a two-channel flash LED driver. It keeps four small configuration fields: flash current, reduced current, steady "movie" light and flash duration. From those fields and a handful of level inputs it produces one current setting, in 10 mA units, for the matched analog regulators, along with an enable for each channel. A rising edge on the trigger input starts a timed flash. The flash lasts for a duration picked by a saturating 5-bit code in 25 ms steps, and it is counted from a prescaled system clock. A software-style write sets the steady light on or off, and it stays on until it is written off.

While a flash is running, either the inhibit input or the low-battery input drops the output to the separate reduced-current field. Full current returns as soon as both inputs go low. A fault flag from the LED short/open detectors latches the driver off until reset.

Top module: `flash_led_ctrl`

## Requirements
- R1: After reset all four configuration fields read as zero, no flash or steady light is active, `i_set` is 0 and `ch_en` is 0.
- R2: During a flash with inhibit and low battery both low, `i_set` equals 5*(F+1), where F is the 4-bit flash field, and codes 14 and 15 both give 75 (750 mA). Every channel bit of `ch_en` is 1 exactly when `i_set` is non-zero.
- R3: A flash starts in the cycle after a low-to-high change of `flash_trig`. A trigger held high, or an edge that arrives while a flash is running, does not start a new flash.
- R4: While a flash runs and `flash_inh` is high, `i_set` equals 5*(H+1), where H is the 3-bit reduced field, except that H=7 gives 35 (350 mA).
- R5: A flash lasts (T+2)*STEP_CYCLES cycles, where T is the 5-bit timer field captured at the start. Any T of 18 or more gives 20*STEP_CYCLES. The flash ends when the count runs out, even if the trigger is still high. `tmr_run` and `flash_evt` are high for exactly that span.
- R6: The steady light is on while its enable bit is 1, and it has no timer. Its 3-bit level maps 0..7 to 2,4,6,8,10,12,15,15 (in 10 mA units). A running flash overrides it, and `movie_evt` is high only when the steady light drives the output.
- R7: While a flash runs and `low_batt` is high, `i_set` uses the reduced field as in R4. Full flash current returns on the cycle `low_batt` falls.
- R8: When `led_fault` is sampled high, from the next cycle until reset `i_set` is 0, any flash is cancelled, the steady light is reported off, and triggers are ignored.
- R9: A write with `wr_en` high loads `wr_data` into the field chosen by `wr_addr`: 0 = flash field [3:0], 1 = reduced field [2:0], 2 = steady light enable [3] and level [2:0], 3 = timer field [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Field select for the write |
| wr_data | input | 5 | Write data |
| flash_trig | input | 1 | Flash trigger, rising edge starts a flash |
| flash_inh | input | 1 | Drop to reduced current during a flash |
| low_batt | input | 1 | Low battery indication |
| led_fault | input | 1 | LED short/open detected |
| i_set | output | 7 | Regulator current, 10 mA units |
| ch_en | output | NUM_CH | Per-channel driver enable |
| flash_evt | output | 1 | Flash in progress |
| movie_evt | output | 1 | Steady light driving the output |
| tmr_run | output | 1 | Flash timer counting |

## Verification
The assertions assume that `flash_trig`, `flash_inh`, `low_batt` and `led_fault` are already synchronous to `clk` and change only between edges. They also assume that `led_fault` stays valid once raised, because the block latches it. The bench drives every input on the falling edge, a half period away from the sampling edge. It follows a directed sequence that holds the trigger across an expiry, retriggers during a flash, and toggles inhibit and low battery inside a flash. It also rewrites the timer mid-flash and raises a fault during steady light.

// File: rtl/flash_led_pkg.sv
package flash_led_pkg;

  localparam int FL_W   = 4;
  localparam int INH_W  = 3;
  localparam int MV_W   = 3;
  localparam int TMR_W  = 5;
  localparam int CUR_W  = 7;
  localparam int STEP_W = 5;

  typedef struct packed {
    logic [FL_W-1:0]  fl;
    logic [INH_W-1:0] inh;
    logic             mv_en;
    logic [MV_W-1:0]  mv;
    logic [TMR_W-1:0] tmr;
  } led_cfg_t;

  function automatic logic [CUR_W-1:0] flash_level(input logic [FL_W-1:0] c);
    if (c >= FL_W'(14)) return CUR_W'(75);
    return CUR_W'(5 * (int'(c) + 1));
  endfunction

  function automatic logic [CUR_W-1:0] inh_level(input logic [INH_W-1:0] c);
    if (c == INH_W'(7)) return CUR_W'(35);
    return CUR_W'(5 * (int'(c) + 1));
  endfunction

  function automatic logic [CUR_W-1:0] movie_level(input logic [MV_W-1:0] c);
    if (c >= MV_W'(6)) return CUR_W'(15);
    return CUR_W'(2 * (int'(c) + 1));
  endfunction

  function automatic logic [STEP_W-1:0] tmr_steps(input logic [TMR_W-1:0] c);
    if (c >= TMR_W'(18)) return STEP_W'(20);
    return STEP_W'(int'(c) + 2);
  endfunction

endpackage

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
  import flash_led_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output led_cfg_t         cfg
);

  led_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      unique case (wr_addr)
        2'd0: cfg_d.fl    = wr_data[FL_W-1:0];
        2'd1: cfg_d.inh   = wr_data[INH_W-1:0];
        2'd2: begin
          cfg_d.mv_en = wr_data[MV_W];
          cfg_d.mv    = wr_data[MV_W-1:0];
        end
        default: cfg_d.tmr = wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/flash_timer.sv
module flash_timer
  import flash_led_pkg::*;
#(
  parameter int STEP_CYCLES = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [STEP_W-1:0] steps,
  output logic              active
);

  localparam int PRE_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CYCLES - 1);

  logic              act_q, act_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [STEP_W-1:0] stp_q, stp_d;

  always_comb begin
    act_d = act_q;
    pre_d = pre_q;
    stp_d = stp_q;
    if (abort) begin
      act_d = 1'b0;
    end else if (!act_q && start) begin
      act_d = 1'b1;
      pre_d = '0;
      stp_d = steps;
    end else if (act_q) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        if (stp_q == STEP_W'(1)) act_d = 1'b0;
        else                     stp_d = stp_q - STEP_W'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pre_q <= '0;
      stp_q <= '0;
    end else begin
      act_q <= act_d;
      pre_q <= pre_d;
      stp_q <= stp_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/flash_cur_sel.sv
module flash_cur_sel
  import flash_led_pkg::*;
(
  input  led_cfg_t         cfg,
  input  logic             flashing,
  input  logic             reduce,
  input  logic             dead,
  output logic [CUR_W-1:0] level,
  output logic             mv_drive
);

  always_comb begin
    level    = '0;
    mv_drive = 1'b0;
    if (dead) begin
      level = '0;
    end else if (flashing) begin
      level = reduce ? inh_level(cfg.inh) : flash_level(cfg.fl);
    end else if (cfg.mv_en) begin
      level    = movie_level(cfg.mv);
      mv_drive = 1'b1;
    end
  end

endmodule

// File: rtl/flash_led_ctrl.sv
module flash_led_ctrl
  import flash_led_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int STEP_CYCLES = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [4:0]        wr_data,
  input  logic              flash_trig,
  input  logic              flash_inh,
  input  logic              low_batt,
  input  logic              led_fault,
  output logic [6:0]        i_set,
  output logic [NUM_CH-1:0] ch_en,
  output logic              flash_evt,
  output logic              movie_evt,
  output logic              tmr_run
);

  led_cfg_t   cfg;
  logic       trig_q;
  logic       fault_q, fault_d;
  logic       start, abort, active, mv_drive;
  logic [CUR_W-1:0] level;

  flash_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  assign fault_d = fault_q | led_fault;
  assign abort   = fault_d;
  assign start   = flash_trig & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      trig_q  <= flash_trig;
      fault_q <= fault_d;
    end
  end

  flash_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .abort  (abort),
    .steps  (tmr_steps(cfg.tmr)),
    .active (active)
  );

  flash_cur_sel u_sel (
    .cfg      (cfg),
    .flashing (active),
    .reduce   (flash_inh | low_batt),
    .dead     (fault_q),
    .level    (level),
    .mv_drive (mv_drive)
  );

  assign i_set     = level;
  assign flash_evt = active;
  assign tmr_run   = active;
  assign movie_evt = mv_drive;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_en[g] = (level != '0);
  end

endmodule

// File: rtl/flash_led_ctrl_chk.sv
module flash_led_ctrl_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flash_trig,
  input logic              flash_inh,
  input logic              low_batt,
  input logic              led_fault,
  input logic [6:0]        i_set,
  input logic [NUM_CH-1:0] ch_en,
  input logic              flash_evt,
  input logic              movie_evt,
  input logic              tmr_run
);

  assert_fault_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    led_fault |=> (i_set == 7'd0 && !flash_evt && !movie_evt));

  assert_flash_from_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_evt) |-> $past(flash_trig));

  assert_reduced_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_evt && (flash_inh || low_batt)) |-> (i_set <= 7'd35));

  assert_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    i_set <= 7'd75);

  assert_channels_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_set != 7'd0) == (ch_en == {NUM_CH{1'b1}}));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_evt && movie_evt));

  assert_timer_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run == flash_evt);

endmodule

bind flash_led_ctrl flash_led_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flash_trig (flash_trig),
  .flash_inh  (flash_inh),
  .low_batt   (low_batt),
  .led_fault  (led_fault),
  .i_set      (i_set),
  .ch_en      (ch_en),
  .flash_evt  (flash_evt),
  .movie_evt  (movie_evt),
  .tmr_run    (tmr_run)
);

// File: tb/tb_flash_led_ctrl.sv
module tb_flash_led_ctrl;

  localparam int S = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic       flash_trig = 1'b0, flash_inh = 1'b0, low_batt = 1'b0, led_fault = 1'b0;
  logic [6:0] i_set;
  logic [1:0] ch_en;
  logic       flash_evt, movie_evt, tmr_run;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_led_ctrl #(.NUM_CH(2), .STEP_CYCLES(S)) dut (.*);

  // reference model state
  int  m_fl, m_inh, m_mv, m_tmr, m_rem;
  bit  m_mven, m_act, m_fault, m_tprev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fl = 0; m_inh = 0; m_mv = 0; m_tmr = 0; m_mven = 0;
      m_act = 0; m_rem = 0; m_fault = 0; m_tprev = 0;
    end else begin
      if (m_fault || led_fault) begin
        m_act = 0; m_rem = 0;
      end else if (!m_act && flash_trig && !m_tprev) begin
        m_act = 1;
        m_rem = ((m_tmr > 18) ? 20 : m_tmr + 2) * S;
      end else if (m_act) begin
        m_rem--;
        if (m_rem == 0) m_act = 0;
      end
      if (led_fault) m_fault = 1;
      m_tprev = flash_trig;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_fl  = wr_data & 15;
          2'd1: m_inh = wr_data & 7;
          2'd2: begin m_mven = wr_data[3]; m_mv = wr_data & 7; end
          default: m_tmr = wr_data;
        endcase
      end
    end
  end

  function automatic int exp_cur();
    int t[8] = '{2, 4, 6, 8, 10, 12, 15, 15};
    if (m_fault) return 0;
    if (m_act) begin
      if (flash_inh || low_batt) return (m_inh == 7) ? 35 : 5 * (m_inh + 1);
      return (50 * (m_fl + 1) > 750) ? 75 : 5 * (m_fl + 1);
    end
    if (m_mven) return t[m_mv];
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison with the model, a half period after the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      int e;
      e = exp_cur();
      if (m_fault) tag = "R8";
      else if (m_act && flash_inh) tag = "R4";
      else if (m_act && low_batt) tag = "R7";
      else if (m_act) tag = "R2";
      else if (m_mven) tag = "R6";
      else tag = "R3";
      chk(tag, int'(i_set), e);
      chk("R2_chen", int'(ch_en), (e != 0) ? 3 : 0);
      chk("R5_flash", int'(flash_evt), int'(m_act));
      chk("R5_tmr", int'(tmr_run), int'(m_act));
      chk("R6_movie", int'(movie_evt), int'(m_mven && !m_act && !m_fault));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 2'(a); wr_data = 5'(d);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_trig(input bit v);
    @(negedge clk); #1; flash_trig = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1", int'(i_set), 0);
    chk("R1", int'(ch_en), 0);
    chk("R1", int'(flash_evt | movie_evt | tmr_run), 0);
    @(negedge clk); #1; rst_n = 1;

    // R9: flash field write, shortest timer
    wr(0, 5); wr(3, 0);
    set_trig(1); set_trig(0);
    wait_cyc(3);
    chk("R9", int'(i_set), 30);
    wait_cyc(12);

    // R3: held trigger across expiry, edge during flash ignored
    set_trig(1); wait_cyc(20);
    chk("R3", int'(flash_evt), 0);
    set_trig(0);
    wr(3, 1);  // 3 steps
    set_trig(1); set_trig(0); wait_cyc(2);
    set_trig(1); set_trig(0);
    wait_cyc(20);

    // R5: saturated timer, mid-flash rewrite has no effect
    wr(3, 25); wr(1, 7); wr(0, 15);
    set_trig(1);
    wait_cyc(5); wr(3, 0);
    wait_cyc(5); flash_inh = 1;
    wait_cyc(2); chk("R4", int'(i_set), 35);
    flash_inh = 0; wait_cyc(1);
    chk("R2", int'(i_set), 75);
    low_batt = 1; wait_cyc(3); low_batt = 0;
    wr(1, 2);
    low_batt = 1; wait_cyc(2);
    chk("R7", int'(i_set), 15);
    low_batt = 0;
    wait_cyc(70);
    chk("R5", int'(flash_evt), 0);
    set_trig(0);

    // R6: steady light, overridden by a flash
    wr(2, 8 | 6);
    wait_cyc(2); chk("R6", int'(i_set), 15);
    wr(2, 8 | 2);
    set_trig(1); set_trig(0);
    wait_cyc(10);
    wr(0, 13);
    wait_cyc(5);
    flash_inh = 1; wait_cyc(3); flash_inh = 0;
    wait_cyc(3);
    chk("R6", int'(i_set), 6);

    // R8: fault latches the driver off
    @(negedge clk); #1; led_fault = 1;
    @(negedge clk); #1; led_fault = 0;
    wait_cyc(2);
    chk("R8", int'(i_set), 0);
    set_trig(1); set_trig(0);
    wait_cyc(4);
    chk("R8", int'(flash_evt), 0);

    // R1: reset clears fields; flash then uses code 0 and 2-step timer
    @(negedge clk); #1; rst_n = 0;
    wait_cyc(2);
    chk("R1", int'(i_set), 0);
    @(negedge clk); #1; rst_n = 1;
    set_trig(1); set_trig(0);
    wait_cyc(2);
    chk("R1", int'(i_set), 5);
    wait_cyc(10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule